// File: doc/BRIEF.md
# Single-Bit Manipulation Unit with Carry Accumulator

This unit executes one single-bit instruction on an 8-bit operand per accepted request. A bit index selects one position of the byte. The operation code chooses among four groups of operations. Set, clear and invert change that bit. Test reports whether the bit is zero. Load and store move the bit between the byte and the carry flag. AND, OR and XOR combine the bit with the carry and leave the result in the carry. Load, store and the three logical combinations each have a variant that first complements the bit (for store, the carry). The caller supplies the byte, the index, the code and the current carry. It gets back the resulting byte, a write-back enable that tells it whether the byte must be stored, the new carry and the zero flag.

The request side is a plain valid strobe with no ready. The unit accepts a request on every cycle in which `in_valid` is high, so the caller never sees back-pressure. Back-to-back requests stream through at one per clock. The result side gives a single-cycle `out_valid` pulse one clock after each accepted request. The caller must take the result in that cycle, because the output side cannot stall. The zero flag is held inside the unit and changes only on a test.

Top module: `bit_ops_unit`

## Requirements
- R1: Each request accepted with `in_valid` high produces exactly one `out_valid` pulse on the next clock, and `out_valid` is low when no request was accepted in the previous cycle. After reset `out_valid`, `out_wr` and `out_z` are 0.
- R2: The bit index is taken modulo 8. Only `in_idx[2:0]` selects the bit, where index k addresses the bit of weight 2^k.
- R3: Codes 0 (set), 1 (clear) and 2 (invert) force the selected bit to 1, force it to 0, or flip it. They leave the other seven bits unchanged, assert `out_wr`, and return the incoming carry unchanged.
- R4: Code 3 (test) sets `out_z` to 1 when the selected bit is 0 and clears it otherwise. It returns the byte unchanged with `out_wr` low, and returns the carry unchanged.
- R5: Code 4 (load) copies the selected bit into the carry. Code 5 (inverted load) copies its complement into the carry. Neither asserts `out_wr`.
- R6: Code 6 (store) writes the incoming carry into the selected bit. Code 7 (inverted store) writes the complement of the carry. Both assert `out_wr`, change no other bit, and leave the carry unchanged.
- R7: Codes 8, 10 and 12 set the carry to the selected bit ANDed, ORed or XORed with the incoming carry. They return the byte unchanged with `out_wr` low.
- R8: Codes 9, 11 and 13 complement the selected bit before the AND, OR or XOR with the carry. They return the byte unchanged with `out_wr` low.
- R9: Every operation other than test leaves `out_z` at its previous value.
- R10: Codes 14 and 15 are reserved. They return the byte unchanged, keep `out_wr` low, and keep both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; the request is accepted on every cycle it is high |
| in_data | input | 8 | Operand byte |
| in_idx | input | 4 | Bit index; only the low 3 bits are used |
| in_op | input | 4 | Operation code |
| in_c | input | 1 | Current carry flag |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | 8 | Resulting byte |
| out_wr | output | 1 | High with `out_valid` when the byte must be written back |
| out_c | output | 1 | New carry flag |
| out_z | output | 1 | Zero flag, updated only by test |

## Verification
A wrong mask decode, or a wrong bit-merge state, would change a bit other than the indexed one or miss the indexed bit. This shows on `out_data` in the cycle of the next `out_valid` pulse. A corrupted zero-flag register cannot stay hidden in test results. It is exposed as soon as any non-test operation follows a test, because `out_z` must then repeat the earlier value exactly. Timing faults in the valid pipeline show within one clock, as a missing, doubled or stretched `out_valid` pulse.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
  localparam int OP_W = 4;

  // Odd codes from 4 to 13 are the inverted-operand forms of the even code below them.
  typedef enum logic [OP_W-1:0] {
    BOP_SET  = 4'd0,
    BOP_CLR  = 4'd1,
    BOP_INV  = 4'd2,
    BOP_TST  = 4'd3,
    BOP_LD   = 4'd4,
    BOP_ILD  = 4'd5,
    BOP_ST   = 4'd6,
    BOP_IST  = 4'd7,
    BOP_AND  = 4'd8,
    BOP_IAND = 4'd9,
    BOP_OR   = 4'd10,
    BOP_IOR  = 4'd11,
    BOP_XOR  = 4'd12,
    BOP_IXOR = 4'd13,
    BOP_RSV0 = 4'd14,
    BOP_RSV1 = 4'd15
  } bop_e;

  typedef struct packed {
    logic wr;
    logic new_bit;
    logic c_next;
    logic z_upd;
    logic z_val;
  } bop_res_t;
endpackage

// File: rtl/bitu_mask.sv
module bitu_mask #(
  parameter int IDX_W  = 3,
  localparam int DATA_W = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] mask
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_dec
    assign mask[k] = (idx == k[IDX_W-1:0]);
  end
endmodule

// File: rtl/bitu_eval.sv
module bitu_eval
  import bitu_pkg::*;
(
  input  bop_e     op,
  input  logic     sel_bit,
  input  logic     c_in,
  output bop_res_t res
);
  logic operand;
  logic [OP_W-1:0] code;

  assign code    = op;
  assign operand = sel_bit ^ code[0];

  always_comb begin
    res.wr      = 1'b0;
    res.new_bit = sel_bit;
    res.c_next  = c_in;
    res.z_upd   = 1'b0;
    res.z_val   = ~sel_bit;
    case (op)
      BOP_SET: begin res.wr = 1'b1; res.new_bit = 1'b1;     end
      BOP_CLR: begin res.wr = 1'b1; res.new_bit = 1'b0;     end
      BOP_INV: begin res.wr = 1'b1; res.new_bit = ~sel_bit; end
      BOP_TST: res.z_upd = 1'b1;
      BOP_LD, BOP_ILD:   res.c_next = operand;
      BOP_ST, BOP_IST: begin
        res.wr      = 1'b1;
        res.new_bit = c_in ^ code[0];
      end
      BOP_AND, BOP_IAND: res.c_next = operand & c_in;
      BOP_OR,  BOP_IOR:  res.c_next = operand | c_in;
      BOP_XOR, BOP_IXOR: res.c_next = operand ^ c_in;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitu_merge.sv
module bitu_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  input  logic              wr,
  input  logic              new_bit,
  output logic [DATA_W-1:0] merged
);
  always_comb begin
    if (wr) merged = (data & ~mask) | (mask & {DATA_W{new_bit}});
    else    merged = data;
  end
endmodule

// File: rtl/bit_ops_unit.sv
module bit_ops_unit
  import bitu_pkg::*;
#(
  parameter int IDX_W    = 3,
  parameter int IDX_IN_W = 4,
  localparam int DATA_W  = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [IDX_IN_W-1:0] in_idx,
  input  logic [OP_W-1:0]     in_op,
  input  logic                in_c,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_wr,
  output logic                out_c,
  output logic                out_z
);
  logic [IDX_W-1:0]  idx_lo;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] merged;
  logic              sel_bit;
  bop_res_t          res;
  bop_e              op;

  assign idx_lo  = in_idx[IDX_W-1:0];
  assign op      = bop_e'(in_op);
  assign sel_bit = |(in_data & mask);

  if (IDX_IN_W > IDX_W) begin : g_idx_hi
    logic unused_idx_hi;
    assign unused_idx_hi = ^in_idx[IDX_IN_W-1:IDX_W];
  end

  bitu_mask #(.IDX_W(IDX_W)) u_mask (.idx(idx_lo), .mask(mask));

  bitu_eval u_eval (.op(op), .sel_bit(sel_bit), .c_in(in_c), .res(res));

  bitu_merge #(.DATA_W(DATA_W)) u_merge (
    .data(in_data), .mask(mask), .wr(res.wr),
    .new_bit(res.new_bit), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wr    <= 1'b0;
      out_data  <= '0;
      out_c     <= 1'b0;
      out_z     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_wr    <= in_valid & res.wr;
      if (in_valid) begin
        out_data <= merged;
        out_c    <= res.c_next;
        if (res.z_upd) out_z <= res.z_val;
      end
    end
  end
endmodule

// File: rtl/bit_ops_chk.sv
module bit_ops_chk #(
  parameter int IDX_W    = 3,
  parameter int IDX_IN_W = 4,
  localparam int DATA_W  = 1 << IDX_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [DATA_W-1:0]   in_data,
  input logic [IDX_IN_W-1:0] in_idx,
  input logic [3:0]          in_op,
  input logic                in_c,
  input logic                out_valid,
  input logic [DATA_W-1:0]   out_data,
  input logic                out_wr,
  input logic                out_c,
  input logic                out_z
);
  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> out_valid);
  // R3
  single_bit_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($countones(out_data ^ $past(in_data)) <= 1));
  // R4
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd3) |=> (!out_wr && out_data == $past(in_data)));
  // R9
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op != 4'd3) |=> $stable(out_z));
  // R3
  set_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 4'd0) |=> out_data[$past(in_idx[IDX_W-1:0])]);
  // R10
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= 4'd14) |=> (!out_wr && out_c == $past(in_c)));
endmodule

bind bit_ops_unit bit_ops_chk #(.IDX_W(IDX_W), .IDX_IN_W(IDX_IN_W)) u_chk (.*);

// File: tb/test_bit_ops_unit.sv
module test_bit_ops_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [3:0] in_idx = '0;
  logic [3:0] in_op = '0;
  logic       in_c = 1'b0;
  logic       out_valid, out_wr, out_c, out_z;
  logic [7:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  logic z_model = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_ops_unit i_bit_ops_unit (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One request; result compared against a model built from the requirements.
  task automatic run_op(input logic [7:0] d, input logic [3:0] idx, input logic [3:0] op,
                        input logic c, input string req);
    logic [7:0] ed; logic ew, ec, b; int k;
    k = idx % 8; b = d[k]; ed = d; ew = 1'b0; ec = c;
    case (op)
      4'd0: begin ed[k] = 1'b1; ew = 1'b1; end
      4'd1: begin ed[k] = 1'b0; ew = 1'b1; end
      4'd2: begin ed[k] = ~b;   ew = 1'b1; end
      4'd3: z_model = (b == 1'b0);
      4'd4: ec = b;
      4'd5: ec = ~b;
      4'd6: begin ed[k] = c;  ew = 1'b1; end
      4'd7: begin ed[k] = ~c; ew = 1'b1; end
      4'd8: ec = b & c;
      4'd9: ec = ~b & c;
      4'd10: ec = b | c;
      4'd11: ec = ~b | c;
      4'd12: ec = b ^ c;
      4'd13: ec = ~b ^ c;
      default: ;
    endcase
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_idx = idx; in_op = op; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "valid", int'(out_valid), 1);
    check(req, "data", int'(out_data), int'(ed));
    check(req, "wr", int'(out_wr), int'(ew));
    check(req, "c", int'(out_c), int'(ec));
    check(req, "z", int'(out_z), int'(z_model));
  endtask

  task automatic t_reset();
    check("R1", "reset valid", int'(out_valid), 0);
    check("R1", "reset wr", int'(out_wr), 0);
    check("R1", "reset z", int'(out_z), 0);
  endtask

  task automatic t_pulse();
    run_op(8'h00, 4'd1, 4'd0, 1'b0, "R1");
    @(negedge clk);
    check("R1", "pulse ends", int'(out_valid), 0);
    check("R1", "wr ends", int'(out_wr), 0);
  endtask

  task automatic t_modify();
    run_op(8'h00, 4'd0, 4'd0, 1'b1, "R3");
    run_op(8'hA5, 4'd6, 4'd0, 1'b0, "R3");
    run_op(8'hFF, 4'd7, 4'd1, 1'b1, "R3");
    run_op(8'h5A, 4'd3, 4'd2, 1'b0, "R3");
    run_op(8'h5A, 4'd4, 4'd2, 1'b1, "R3");
  endtask

  task automatic t_index_mod();
    run_op(8'h00, 4'd11, 4'd0, 1'b0, "R2");
    run_op(8'hFF, 4'd15, 4'd1, 1'b0, "R2");
    run_op(8'h04, 4'd10, 4'd4, 1'b0, "R2");
  endtask

  task automatic t_test_and_hold();
    run_op(8'hEF, 4'd4, 4'd3, 1'b1, "R4");
    run_op(8'hFF, 4'd2, 4'd1, 1'b0, "R9");
    run_op(8'h00, 4'd5, 4'd8, 1'b1, "R9");
    run_op(8'h10, 4'd4, 4'd3, 1'b0, "R4");
    run_op(8'h00, 4'd4, 4'd4, 1'b1, "R9");
  endtask

  task automatic t_load_store();
    for (int c = 0; c < 2; c++) begin
      run_op(8'h80, 4'd7, 4'd4, c[0], "R5");
      run_op(8'h80, 4'd7, 4'd5, c[0], "R5");
      run_op(8'h3C, 4'd2, 4'd6, c[0], "R6");
      run_op(8'h3C, 4'd0, 4'd7, c[0], "R6");
    end
  endtask

  task automatic t_logic();
    for (int op = 8; op < 14; op++)
      for (int bv = 0; bv < 2; bv++)
        for (int c = 0; c < 2; c++)
          run_op(bv[0] ? 8'h02 : 8'hFD, 4'd1, op[3:0], c[0], (op % 2 == 0) ? "R7" : "R8");
  endtask

  task automatic t_reserved();
    run_op(8'h00, 4'd3, 4'd3, 1'b0, "R4");
    run_op(8'h69, 4'd2, 4'd14, 1'b1, "R10");
    run_op(8'h96, 4'd5, 4'd15, 1'b0, "R10");
  endtask

  task automatic t_stream();
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h00; in_idx = 4'd2; in_op = 4'd0; in_c = 1'b0;
    @(negedge clk);
    check("R1", "stream first valid", int'(out_valid), 1);
    check("R3", "stream first data", int'(out_data), 8'h04);
    in_data = 8'hF0; in_idx = 4'd5; in_op = 4'd4; in_c = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "stream second valid", int'(out_valid), 1);
    check("R5", "stream second c", int'(out_c), 1);
    check("R5", "stream second wr", int'(out_wr), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_pulse();
    t_modify();
    t_index_mod();
    t_test_and_hold();
    t_load_store();
    t_logic();
    t_reserved();
    t_stream();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule